// File: doc/BRIEF.md
# Stacked Register Frame Engine

This block manages the stacked half of a 128-entry logical general register space. Logical registers 0 to 31 are global and are never renamed. Logical registers 32 to 127 are mapped onto a ring of physical registers, which holds 96 entries by default. Procedure frames are laid into that ring one after another. Every procedure sees its own first frame register as logical 32. The engine keeps a current frame marker (frame size, locals size, rotating size, rename base) and a previous frame marker. It also keeps two backing-store addresses: the frame pointer, which is the memory image address of the current frame base, and the store pointer, which is the next free spill word.

Three operations are accepted: allocate, call and return. On a call, the caller's output registers become the callee's inputs. The frame base moves forward by the caller's locals size, and the callee starts with a frame made only of those outputs. The caller's marker is copied into the previous marker. On a return, the current marker is taken back from the previous marker and the base moves back. An allocate that would overflow the ring first spills the oldest resident caller registers to memory, one 64-bit word per cycle. A return whose caller registers were spilled first fills them back, one word per cycle. The register file storage itself sits outside the block and is reached through a read port and a write port.

The controller is a five-state machine. IDLE accepts an operation and moves to EVAL. EVAL leaves for IDLE when the operation is illegal. It leaves for SPILL when an allocate needs room, for FILL when a return needs registers back, and otherwise for COMMIT. SPILL and FILL each loop once per word and move to COMMIT after the last word. COMMIT applies the marker and pointer update and returns to IDLE.

Top module: `stack_frame_engine`

## Requirements
- R1: After reset the current and previous frame markers are zero, both backing-store pointers equal the BASE_ADDR parameter, and op_ready is high.
- R2: For map_lreg below 32 the mapper reports map_stacked=0, map_in_frame=1 and map_preg equal to map_lreg. For map_lreg L of 32 or more it reports map_stacked=1 and map_preg=(base + L - 32) mod 96. map_in_frame is 1 exactly when L < 32 + current frame size.
- R3: An allocate (op_code 0) is illegal when its frame size exceeds 96, or when its locals size or rotating size exceeds its frame size. op_code 3 is always illegal. For an illegal operation, op_illegal pulses in the cycle after acceptance and no marker or pointer changes.
- R4: A legal allocate sets the current marker to the requested sizes with rename base 0 and leaves the base and the frame pointer unchanged. Marker fields are packed as frame size [6:0], locals [13:7], rotating [20:14], rename base [27:21].
- R5: A call (op_code 1) copies the current marker into the previous marker. It advances the base by the locals size and the frame pointer by 8 times the locals size, and it sets the current marker to frame size minus locals size, with the other fields zero.
- R6: A return (op_code 2) restores the current marker from the previous marker. It moves the base back by the restored locals size and the frame pointer back by 8 times that size.
- R7: When the resident caller registers plus a requested frame size exceed 96, an allocate spills exactly the excess. It goes oldest register first, one word per cycle, to rising addresses starting at the store pointer, which advances by 8 per word. An excess of zero spills nothing.
- R8: When fewer caller registers are resident than the restored locals size, a return first fills exactly the shortfall. It goes most recently spilled word first, one read per cycle, to falling addresses. Each word is written into the register file the cycle after its read. No other physical register is written.
- R9: op_ready is low from acceptance until the operation ends. op_done pulses for one cycle in the last cycle of a legal operation, and its results are visible in the following cycle. A spilling or filling operation lasts N+2 cycles for N words.
- R10: The physical index wraps modulo 96, so a frame that crosses the ring end maps its upper registers to the low physical entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation request, held until accepted |
| op_code | input | 2 | 0 allocate, 1 call, 2 return, 3 illegal |
| op_sof | input | 7 | Requested frame size (allocate) |
| op_sol | input | 7 | Requested locals size (allocate) |
| op_sor | input | 7 | Requested rotating size (allocate) |
| op_ready | output | 1 | Engine idle, request accepted this cycle |
| op_done | output | 1 | Last cycle of a legal operation |
| op_illegal | output | 1 | Operation rejected |
| map_lreg | input | 7 | Logical register to translate |
| map_preg | output | 7 | Physical ring index, or the global number |
| map_stacked | output | 1 | Logical register lies in the stacked region |
| map_in_frame | output | 1 | Logical register is inside the current frame |
| cur_frame | output | 28 | Current frame marker |
| prev_frame | output | 28 | Previous frame marker |
| bs_ptr | output | 32 | Backing-store address of the current frame base |
| bs_store_ptr | output | 32 | Next free backing-store word |
| rf_rd_idx | output | 7 | Register file read index for spills |
| rf_rd_data | input | 64 | Register file read data, same cycle |
| rf_wr_en | output | 1 | Register file write for fills |
| rf_wr_idx | output | 7 | Register file write index |
| rf_wr_data | output | 64 | Register file write data |
| mem_wr_en | output | 1 | Backing-store word write |
| mem_rd_en | output | 1 | Backing-store word read |
| mem_addr | output | 32 | Backing-store byte address |
| mem_wdata | output | 64 | Spill data |
| mem_rdata | input | 64 | Fill data, one cycle after mem_rd_en |

## Verification
The bench builds a caller frame whose outputs become the callee's inputs. The callee then allocates 80 registers, so 34 older words must spill. A design that took the spill index from the wrong end of the ring, or mis-sized the excess, would leave backing-store words that do not match the original register values. The following return must fill the same 34 words in reverse. An off-by-one in the fill index or in the read-to-write pipeline would show up as wrong or clobbered registers, and a design that refilled too much would overwrite registers the bench poisoned. The bench also probes the boundaries: a frame that exactly fills the ring must cause no traffic, a mapping must wrap past index 95, and illegal allocates must leave every marker untouched.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
    localparam int FW = 7;   // width of every frame marker field
    localparam int LW = 7;   // logical register number width (128 registers)
    localparam int GLOBALS = 32;

    typedef enum logic [1:0] {
        OP_ALLOC = 2'd0,
        OP_CALL  = 2'd1,
        OP_RET   = 2'd2,
        OP_BAD   = 2'd3
    } sfe_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_SPILL,
        ST_FILL,
        ST_COMMIT
    } sfe_state_e;

    typedef struct packed {
        logic [FW-1:0] rrb;
        logic [FW-1:0] sor;
        logic [FW-1:0] sol;
        logic [FW-1:0] sof;
    } sfe_marker_t;
endpackage

// File: rtl/sfe_map.sv
module sfe_map
    import sfe_pkg::*;
#(
    parameter int NSTK = 96,
    parameter int PW   = $clog2(NSTK)
) (
    input  logic [LW-1:0] lreg,
    input  logic [PW-1:0] bof,
    input  logic [FW-1:0] sof,
    output logic [LW-1:0] preg,
    output logic          stacked,
    output logic          in_frame
);
    function automatic logic [PW-1:0] ring_add(input logic [PW-1:0] a, input int b);
        int s;
        s = int'(a) + b;
        if (s >= NSTK) s = s - NSTK;
        return PW'(s);
    endfunction

    logic [LW-1:0] offset;
    logic [PW-1:0] ring_idx;

    always_comb begin
        stacked  = (lreg >= LW'(GLOBALS));
        offset   = lreg - LW'(GLOBALS);
        ring_idx = ring_add(bof, int'(offset));
        if (stacked) begin
            preg     = LW'(ring_idx);
            in_frame = (int'(offset) < int'(sof));
        end else begin
            preg     = lreg;
            in_frame = 1'b1;
        end
    end
endmodule

// File: rtl/sfe_xfer.sv
module sfe_xfer
    import sfe_pkg::*;
#(
    parameter int NSTK = 96,
    parameter int PW   = $clog2(NSTK),
    parameter int CW   = $clog2(NSTK + 1),
    parameter int AW   = 32,
    parameter int DW   = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spill_act,
    input  logic          fill_act,
    input  logic [PW-1:0] bof,
    input  logic [CW-1:0] nd,
    input  logic [AW-1:0] bs_store,
    input  logic [DW-1:0] rf_rd_data,
    input  logic [DW-1:0] mem_rdata,
    output logic [PW-1:0] rf_rd_idx,
    output logic          rf_wr_en,
    output logic [PW-1:0] rf_wr_idx,
    output logic [DW-1:0] rf_wr_data,
    output logic          mem_wr_en,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata
);
    localparam int WORD_BYTES = DW / 8;

    function automatic logic [PW-1:0] ring_sub(input logic [PW-1:0] a, input int b);
        int s;
        s = int'(a) - b;
        if (s < 0) s = s + NSTK;
        return PW'(s);
    endfunction

    logic [PW-1:0] spill_idx;
    logic [PW-1:0] fill_idx;
    logic          fill_v_q;
    logic [PW-1:0] fill_idx_q;

    // Oldest resident register sits nd entries below the base; the next one
    // to refill sits just below the oldest still resident.
    always_comb begin
        spill_idx = ring_sub(bof, int'(nd));
        fill_idx  = ring_sub(bof, int'(nd) + 1);
        rf_rd_idx = spill_idx;
        mem_wdata = rf_rd_data;
        mem_wr_en = spill_act;
        mem_rd_en = fill_act;
        mem_addr  = fill_act ? (bs_store - AW'(WORD_BYTES)) : bs_store;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_v_q   <= 1'b0;
            fill_idx_q <= '0;
        end else begin
            fill_v_q   <= fill_act;
            fill_idx_q <= fill_idx;
        end
    end

    assign rf_wr_en   = fill_v_q;
    assign rf_wr_idx  = fill_idx_q;
    assign rf_wr_data = mem_rdata;
endmodule

// File: rtl/stack_frame_engine.sv
module stack_frame_engine
    import sfe_pkg::*;
#(
    parameter int          NSTK      = 96,
    parameter int          AW        = 32,
    parameter int          DW        = 64,
    parameter logic [31:0] BASE_ADDR = 32'h0000_1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [1:0]    op_code,
    input  logic [6:0]    op_sof,
    input  logic [6:0]    op_sol,
    input  logic [6:0]    op_sor,
    output logic          op_ready,
    output logic          op_done,
    output logic          op_illegal,
    input  logic [6:0]    map_lreg,
    output logic [6:0]    map_preg,
    output logic          map_stacked,
    output logic          map_in_frame,
    output logic [27:0]   cur_frame,
    output logic [27:0]   prev_frame,
    output logic [AW-1:0] bs_ptr,
    output logic [AW-1:0] bs_store_ptr,
    output logic [6:0]    rf_rd_idx,
    input  logic [DW-1:0] rf_rd_data,
    output logic          rf_wr_en,
    output logic [6:0]    rf_wr_idx,
    output logic [DW-1:0] rf_wr_data,
    output logic          mem_wr_en,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);
    localparam int PW         = $clog2(NSTK);
    localparam int CW         = $clog2(NSTK + 1);
    localparam int WORD_SHIFT = $clog2(DW / 8);

    function automatic logic [PW-1:0] ring_add(input logic [PW-1:0] a, input int b);
        int s;
        s = int'(a) + b;
        if (s >= NSTK) s = s - NSTK;
        return PW'(s);
    endfunction

    function automatic logic [PW-1:0] ring_sub(input logic [PW-1:0] a, input int b);
        int s;
        s = int'(a) - b;
        if (s < 0) s = s + NSTK;
        return PW'(s);
    endfunction

    sfe_state_e  state_q, state_d;
    sfe_op_e     op_q;
    logic [FW-1:0] req_sof_q, req_sol_q, req_sor_q;
    sfe_marker_t cfm_q, pfs_q;
    logic [PW-1:0] bof_q;
    logic [AW-1:0] bsp_q;
    logic [CW-1:0] nd_q;
    logic [CW-1:0] left_q;

    logic          bad;
    int            spill_need;
    int            fill_need;
    logic          spill_act;
    logic          fill_act;
    logic [AW-1:0] bs_store;

    // ---------------- evaluation of the pending operation ----------------
    always_comb begin
        bad = 1'b0;
        if (op_q == OP_BAD) begin
            bad = 1'b1;
        end else if (op_q == OP_ALLOC) begin
            bad = (int'(req_sof_q) > NSTK) || (req_sol_q > req_sof_q) || (req_sor_q > req_sof_q);
        end

        spill_need = 0;
        if (op_q == OP_ALLOC && (int'(nd_q) + int'(req_sof_q) > NSTK)) begin
            spill_need = int'(nd_q) + int'(req_sof_q) - NSTK;
        end

        fill_need = 0;
        if (op_q == OP_RET && (int'(pfs_q.sol) > int'(nd_q))) begin
            fill_need = int'(pfs_q.sol) - int'(nd_q);
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (op_valid) state_d = ST_EVAL;
            ST_EVAL: begin
                if (bad)                 state_d = ST_IDLE;
                else if (spill_need > 0) state_d = ST_SPILL;
                else if (fill_need > 0)  state_d = ST_FILL;
                else                     state_d = ST_COMMIT;
            end
            ST_SPILL:  if (left_q == CW'(1)) state_d = ST_COMMIT;
            ST_FILL:   if (left_q == CW'(1)) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        op_ready   = 1'b0;
        op_done    = 1'b0;
        op_illegal = 1'b0;
        spill_act  = 1'b0;
        fill_act   = 1'b0;
        unique case (state_q)
            ST_IDLE:   op_ready   = 1'b1;
            ST_EVAL:   op_illegal = bad;
            ST_SPILL:  spill_act  = 1'b1;
            ST_FILL:   fill_act   = 1'b1;
            ST_COMMIT: op_done    = 1'b1;
            default: ;
        endcase
    end

    // ---------------- datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q      <= OP_ALLOC;
            req_sof_q <= '0;
            req_sol_q <= '0;
            req_sor_q <= '0;
            cfm_q     <= '0;
            pfs_q     <= '0;
            bof_q     <= '0;
            bsp_q     <= AW'(BASE_ADDR);
            nd_q      <= '0;
            left_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (op_valid) begin
                        op_q      <= sfe_op_e'(op_code);
                        req_sof_q <= op_sof;
                        req_sol_q <= op_sol;
                        req_sor_q <= op_sor;
                    end
                end
                ST_EVAL: begin
                    if (spill_need > 0)     left_q <= CW'(spill_need);
                    else if (fill_need > 0) left_q <= CW'(fill_need);
                    else                    left_q <= '0;
                end
                ST_SPILL: begin
                    nd_q   <= nd_q - CW'(1);
                    left_q <= left_q - CW'(1);
                end
                ST_FILL: begin
                    nd_q   <= nd_q + CW'(1);
                    left_q <= left_q - CW'(1);
                end
                ST_COMMIT: begin
                    unique case (op_q)
                        OP_ALLOC: begin
                            cfm_q.sof <= req_sof_q;
                            cfm_q.sol <= req_sol_q;
                            cfm_q.sor <= req_sor_q;
                            cfm_q.rrb <= '0;
                        end
                        OP_CALL: begin
                            pfs_q     <= cfm_q;
                            bof_q     <= ring_add(bof_q, int'(cfm_q.sol));
                            bsp_q     <= bsp_q + (AW'(cfm_q.sol) << WORD_SHIFT);
                            nd_q      <= nd_q + CW'(cfm_q.sol);
                            cfm_q.sof <= cfm_q.sof - cfm_q.sol;
                            cfm_q.sol <= '0;
                            cfm_q.sor <= '0;
                            cfm_q.rrb <= '0;
                        end
                        OP_RET: begin
                            cfm_q <= pfs_q;
                            bof_q <= ring_sub(bof_q, int'(pfs_q.sol));
                            bsp_q <= bsp_q - (AW'(pfs_q.sol) << WORD_SHIFT);
                            nd_q  <= nd_q - CW'(pfs_q.sol);
                        end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    assign bs_store     = bsp_q - (AW'(nd_q) << WORD_SHIFT);
    assign bs_store_ptr = bs_store;
    assign bs_ptr       = bsp_q;
    assign cur_frame    = cfm_q;
    assign prev_frame   = pfs_q;

    // ---------------- sub-blocks ----------------
    logic [PW-1:0] map_ring_bof;
    assign map_ring_bof = bof_q;

    sfe_map #(.NSTK(NSTK), .PW(PW)) u_map (
        .lreg     (map_lreg),
        .bof      (map_ring_bof),
        .sof      (cfm_q.sof),
        .preg     (map_preg),
        .stacked  (map_stacked),
        .in_frame (map_in_frame)
    );

    logic [PW-1:0] xf_rd_idx, xf_wr_idx;

    sfe_xfer #(.NSTK(NSTK), .PW(PW), .CW(CW), .AW(AW), .DW(DW)) u_xfer (
        .clk        (clk),
        .rst_n      (rst_n),
        .spill_act  (spill_act),
        .fill_act   (fill_act),
        .bof        (bof_q),
        .nd         (nd_q),
        .bs_store   (bs_store),
        .rf_rd_data (rf_rd_data),
        .mem_rdata  (mem_rdata),
        .rf_rd_idx  (xf_rd_idx),
        .rf_wr_en   (rf_wr_en),
        .rf_wr_idx  (xf_wr_idx),
        .rf_wr_data (rf_wr_data),
        .mem_wr_en  (mem_wr_en),
        .mem_rd_en  (mem_rd_en),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );

    assign rf_rd_idx = 7'(xf_rd_idx);
    assign rf_wr_idx = 7'(xf_wr_idx);
endmodule

// File: rtl/sfe_checker.sv
module sfe_checker #(
    parameter int NSTK = 96,
    parameter int AW   = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic          op_ready,
    input logic          op_done,
    input logic          op_illegal,
    input logic [6:0]    map_preg,
    input logic          map_stacked,
    input logic          map_in_frame,
    input logic [27:0]   cur_frame,
    input logic [27:0]   prev_frame,
    input logic [AW-1:0] bs_store_ptr,
    input logic          mem_wr_en,
    input logic          mem_rd_en,
    input logic          rf_wr_en
);
    // R2: a translated stacked register always lands inside the ring
    assert_map_in_ring_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (map_stacked && map_in_frame) |-> (int'(map_preg) < NSTK));

    // R3: a rejected operation leaves both markers untouched
    assert_illegal_keeps_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
        op_illegal |=> (cur_frame == $past(cur_frame) && prev_frame == $past(prev_frame)));

    // R4: the current frame never exceeds the ring
    assert_frame_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cur_frame[6:0]) <= NSTK);

    // R7: each spilled word advances the store pointer by one word
    assert_spill_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> (bs_store_ptr == $past(bs_store_ptr) + AW'(8)));

    // R7/R8: spill and fill never overlap
    assert_no_rw_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr_en && mem_rd_en));

    // R8: every fill read is followed by a register file write
    assert_fill_writes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> rf_wr_en);

    // R8: each filled word moves the store pointer back by one word
    assert_fill_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> (bs_store_ptr == $past(bs_store_ptr) - AW'(8)));

    // R9: an accepted request drops ready in the next cycle
    assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready) |=> !op_ready);

    // R9: completion and readiness are exclusive
    assert_done_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> !op_ready);

    // R9: a single operation completes at most once
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done);
endmodule

bind stack_frame_engine sfe_checker #(.NSTK(NSTK), .AW(AW)) u_chk (.*);

// File: tb/stack_frame_engine_tb.sv
module stack_frame_engine_tb;
    localparam logic [31:0] BASE = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_code = 2'd0;
    logic [6:0]  op_sof = '0, op_sol = '0, op_sor = '0;
    logic        op_ready, op_done, op_illegal;
    logic [6:0]  map_lreg = '0;
    logic [6:0]  map_preg;
    logic        map_stacked, map_in_frame;
    logic [27:0] cur_frame, prev_frame;
    logic [31:0] bs_ptr, bs_store_ptr;
    logic [6:0]  rf_rd_idx;
    logic [63:0] rf_rd_data;
    logic        rf_wr_en;
    logic [6:0]  rf_wr_idx;
    logic [63:0] rf_wr_data;
    logic        mem_wr_en, mem_rd_en;
    logic [31:0] mem_addr;
    logic [63:0] mem_wdata;
    logic [63:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    int n_wr = 0, n_rd = 0, n_rfw = 0;
    bit finished = 1'b0;

    logic [63:0] rf  [0:95];
    logic [63:0] mem [0:255];

    // 20 time units per period: 50 MHz with 1 ns units
    always #10 clk = ~clk;

    stack_frame_engine #(.BASE_ADDR(BASE)) u_dut (.*);

    assign rf_rd_data = (rf_rd_idx < 7'd96) ? rf[rf_rd_idx] : 64'h0;

    always @(posedge clk) begin
        if (mem_wr_en) begin
            mem[8'((mem_addr - BASE) >> 3)] <= mem_wdata;
            n_wr <= n_wr + 1;
        end
        if (mem_rd_en) begin
            mem_rdata <= mem[8'((mem_addr - BASE) >> 3)];
            n_rd <= n_rd + 1;
        end
        if (rf_wr_en) begin
            rf[rf_wr_idx] <= rf_wr_data;
            n_rfw <= n_rfw + 1;
        end
    end

    function automatic logic [63:0] seed(input int i);
        return {32'hC0DE_0000 + 32'(i), 32'h0000_0100 + 32'(i * 3)};
    endfunction

    function automatic logic [27:0] pk(input int sof, input int sol, input int sor);
        return {7'd0, 7'(sor), 7'(sol), 7'(sof)};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic [1:0] code, input int s, input int l, input int r,
                         output int cyc, output bit ill, output bit rdy_after);
        @(negedge clk);
        op_valid = 1'b1; op_code = code;
        op_sof = 7'(s); op_sol = 7'(l); op_sor = 7'(r);
        @(negedge clk);
        op_valid = 1'b0;
        rdy_after = op_ready;
        cyc = 1;
        while (!op_done && !op_illegal && cyc < 1000) begin
            @(negedge clk);
            cyc++;
        end
        ill = op_illegal;
        @(negedge clk);
    endtask

    task automatic probe(input int lreg, output logic [6:0] p, output logic st, output logic inf);
        map_lreg = 7'(lreg);
        #1;
        p = map_preg; st = map_stacked; inf = map_in_frame;
    endtask

    task automatic t_reset();
        check(cur_frame == 28'd0, "R1 cur_frame", 64'(cur_frame), 0);
        check(prev_frame == 28'd0, "R1 prev_frame", 64'(prev_frame), 0);
        check(bs_ptr == BASE && bs_store_ptr == BASE, "R1 pointers", 64'(bs_store_ptr), 64'(BASE));
        check(op_ready == 1'b1, "R1 op_ready", 64'(op_ready), 1);
    endtask

    task automatic t_map_global();
        logic [6:0] p; logic st, inf;
        probe(5, p, st, inf);
        check(p == 7'd5 && !st && inf, "R2 global passthrough", {p, st, inf}, {7'd5, 2'b01});
        probe(32, p, st, inf);
        check(st && !inf, "R2 empty frame excludes r32", {st, inf}, 2'b10);
    endtask

    task automatic t_alloc();
        int cyc; bit ill, rdy; int w0;
        logic [6:0] p; logic st, inf;
        w0 = n_wr;
        do_op(2'd0, 60, 50, 3, cyc, ill, rdy);
        check(!ill && cur_frame == pk(60, 50, 3), "R4 alloc marker", 64'(cur_frame), 64'(pk(60, 50, 3)));
        check(bs_ptr == BASE && n_wr == w0, "R4 alloc no pointer move", 64'(bs_ptr), 64'(BASE));
        check(cyc == 2, "R9 alloc latency", 64'(cyc), 2);
        probe(91, p, st, inf);
        check(p == 7'd59 && st && inf, "R2 last frame reg", {p, st, inf}, {7'd59, 2'b11});
        probe(92, p, st, inf);
        check(!inf, "R2 beyond frame", 64'(inf), 0);
    endtask

    task automatic t_illegal();
        int cyc; bit ill, rdy;
        do_op(2'd0, 97, 0, 0, cyc, ill, rdy);
        check(ill && cur_frame == pk(60, 50, 3), "R3 oversize alloc", 64'(cur_frame), 64'(pk(60, 50, 3)));
        do_op(2'd0, 10, 11, 0, cyc, ill, rdy);
        check(ill && cur_frame == pk(60, 50, 3), "R3 locals over frame", 64'(cur_frame), 64'(pk(60, 50, 3)));
        do_op(2'd0, 10, 5, 12, cyc, ill, rdy);
        check(ill, "R3 rotating over frame", 64'(ill), 1);
        do_op(2'd3, 0, 0, 0, cyc, ill, rdy);
        check(ill && prev_frame == 28'd0 && bs_ptr == BASE, "R3 bad opcode", 64'(prev_frame), 0);
    endtask

    task automatic t_call();
        int cyc; bit ill, rdy;
        logic [6:0] p; logic st, inf;
        do_op(2'd1, 0, 0, 0, cyc, ill, rdy);
        check(prev_frame == pk(60, 50, 3), "R5 marker saved", 64'(prev_frame), 64'(pk(60, 50, 3)));
        check(cur_frame == pk(10, 0, 0), "R5 callee frame", 64'(cur_frame), 64'(pk(10, 0, 0)));
        check(bs_ptr == BASE + 32'd400, "R5 frame pointer", 64'(bs_ptr), 64'(BASE + 32'd400));
        probe(32, p, st, inf);
        check(p == 7'd50, "R5 outputs become inputs", 64'(p), 50);
        probe(41, p, st, inf);
        check(p == 7'd59 && inf, "R2 callee last reg", 64'(p), 59);
    endtask

    task automatic t_spill();
        int cyc; bit ill, rdy; int w0; bit ok;
        logic [6:0] p; logic st, inf;
        w0 = n_wr;
        do_op(2'd0, 80, 80, 0, cyc, ill, rdy);
        check(rdy == 1'b0, "R9 stall while spilling", 64'(rdy), 0);
        check(n_wr - w0 == 34, "R7 spill count", 64'(n_wr - w0), 34);
        check(cyc == 36, "R7 one word per cycle", 64'(cyc), 36);
        ok = 1'b1;
        for (int i = 0; i < 34; i++) if (mem[i] !== seed(i)) ok = 1'b0;
        check(ok, "R7 oldest first contents", mem[0], seed(0));
        check(bs_store_ptr == BASE + 32'd272 && bs_ptr == BASE + 32'd400, "R7 store pointer",
              64'(bs_store_ptr), 64'(BASE + 32'd272));
        probe(111, p, st, inf);
        check(p == 7'd33 && inf, "R10 ring wrap", 64'(p), 33);
        for (int i = 0; i < 96; i++) rf[i] = 64'hDEAD_BEEF_DEAD_BEEF;
    endtask

    task automatic t_fill();
        int cyc; bit ill, rdy; int r0, f0; bit ok, kept;
        r0 = n_rd; f0 = n_rfw;
        do_op(2'd2, 0, 0, 0, cyc, ill, rdy);
        check(n_rd - r0 == 34 && n_rfw - f0 == 34, "R8 fill count", 64'(n_rd - r0), 34);
        check(cyc == 36, "R8 one word per cycle", 64'(cyc), 36);
        ok = 1'b1;
        for (int i = 0; i < 34; i++) if (rf[i] !== seed(i)) ok = 1'b0;
        check(ok, "R8 registers restored", rf[33], seed(33));
        kept = 1'b1;
        for (int i = 34; i < 96; i++) if (rf[i] !== 64'hDEAD_BEEF_DEAD_BEEF) kept = 1'b0;
        check(kept, "R8 no extra writes", rf[34], 64'hDEAD_BEEF_DEAD_BEEF);
        check(cur_frame == pk(60, 50, 3), "R6 marker restored", 64'(cur_frame), 64'(pk(60, 50, 3)));
        check(bs_ptr == BASE && bs_store_ptr == BASE, "R6 pointers back", 64'(bs_ptr), 64'(BASE));
    endtask

    task automatic t_quiet();
        int cyc; bit ill, rdy; int w0, r0;
        logic [6:0] p; logic st, inf;
        w0 = n_wr; r0 = n_rd;
        do_op(2'd1, 0, 0, 0, cyc, ill, rdy);
        do_op(2'd0, 46, 0, 0, cyc, ill, rdy);
        check(n_wr == w0 && cyc == 2, "R7 exact fit no spill", 64'(n_wr - w0), 0);
        probe(77, p, st, inf);
        check(p == 7'd95 && inf, "R10 ring top", 64'(p), 95);
        do_op(2'd2, 0, 0, 0, cyc, ill, rdy);
        check(n_rd == r0 && cyc == 2, "R8 resident return no fill", 64'(n_rd - r0), 0);
        check(bs_ptr == BASE && cur_frame == pk(60, 50, 3), "R6 quiet return", 64'(bs_ptr), 64'(BASE));
    endtask

    initial begin
        for (int i = 0; i < 96; i++) rf[i] = seed(i);
        for (int i = 0; i < 256; i++) mem[i] = 64'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map_global();
        t_alloc();
        t_illegal();
        t_call();
        t_spill();
        t_fill();
        t_quiet();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule